// File: doc/BRIEF.md
# Cache ECC Fault Injection Controller

This block is a small per-core control bank for deliberately corrupting a SECDED-protected cache. Software programs three 64-bit registers through a plain register port. A control word enables injection, chooses the target array and names the banks. A delay word holds an optional countdown. A mask word gives the bits to invert. When the bank is armed, it raises an injection request toward the cache access path. The request carries the target select, the bank vector and the flip mask. It stays up until the cache reports, through an access-consumed strobe, that an access has taken the corruption.

Injection can fire at once or after a countdown of core clocks. It can happen once, in which case the enable bit drops by itself. In persist mode the countdown reloads from the last value written to the delay register, and the request arms again after each injection. A write to the delay register during a countdown restarts the count from the new value.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, the control, delay and mask registers read as zero and inj_valid_o is low.
- R2: The registers are decoded from reg_addr_i[6:3]: word 0 is control, word 1 is delay and word 2 is mask. reg_addr_i[2:0] is ignored. Any other word in the 128-byte window reads zero, and a write to it changes nothing.
- R3: Control bit 0 is enable, bit 1 is persist, bit 2 is delay enable and bit 3 is the component select (0 = tag, 1 = data). Bits [8+NUM_BANKS-1:8] hold the bank-valid vector. All other control bits read zero.
- R4: With enable 1 and delay enable 0, inj_valid_o is high in the cycle after the control write. inj_valid_o is never high while enable is 0.
- R5: With enable 1 and delay enable 1, the counter loses one per clock. inj_valid_o rises D clocks after the control write, where D is the counter value at that write.
- R6: inj_valid_o stays high until acc_done_i is sampled high with it. While it is high, inj_bank_o and inj_data_sel_o show the programmed bank vector and component.
- R7: With persist 0, an injection that completes (inj_valid_o and acc_done_i high on the same edge) clears the enable bit, and inj_valid_o is low in the next cycle.
- R8: With persist 1, a completed injection reloads the counter from the last value written to the delay register. With delay enable set, the request arms again after that many clocks, and the enable bit stays 1.
- R9: When the target is the tag array, inj_mask_o bits at TAG_W and above are zero. When the target is the data array, inj_mask_o equals the whole mask register.
- R10: A write to the delay register loads the counter at once, also during a countdown, and becomes the new reload value.
- R11: acc_done_i has no effect on any register while inj_valid_o is low.
- R12: The delay register keeps only DLY_W bits. Higher bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when 1, read when 0 |
| reg_addr_i | input | ADDR_W | Byte offset in the window |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i (combinational) |
| acc_done_i | input | 1 | A cache access took the pending injection |
| inj_valid_o | output | 1 | Injection request armed |
| inj_data_sel_o | output | 1 | Target: 0 tag array, 1 data array |
| inj_bank_o | output | NUM_BANKS | Banks whose mask is applied |
| inj_mask_o | output | DATA_W | Bits to invert, shaped for the target |

## Verification
The properties assume that acc_done_i is meaningful only as a reply to a raised request. They also assume that a register write and a completed injection on the same edge resolve in favour of the write, so every property that concerns hold, clear or reload is qualified by the absence of a control or delay write. The bench pulses acc_done_i only at chosen points, well apart from its register writes. It also pulses it once with no request pending, to show that the strobe is ignored there. Every input changes on the falling clock edge.

// File: rtl/ecc_inject_pkg.sv
package ecc_inject_pkg;
  localparam int REG_CTL = 0;
  localparam int REG_DLY = 1;
  localparam int REG_MSK = 2;
  localparam int CTL_BANK_LSB = 8;

  typedef struct packed {
    logic cmp;
    logic ede;
    logic pst;
    logic en;
  } ctl_flags_t;
endpackage

// File: rtl/ecc_inject_regs.sv
module ecc_inject_regs
  import ecc_inject_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 7,
  parameter int NUM_BANKS = 8,
  parameter int DLY_W     = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 success_i,
  output ctl_flags_t           flags_o,
  output logic [NUM_BANKS-1:0] bank_o,
  output logic [DATA_W-1:0]    mask_o,
  output logic [DLY_W-1:0]     reload_o,
  output logic                 ctl_wr_o,
  output logic                 dly_wr_o,
  output logic [DLY_W-1:0]     dly_val_o
);
  localparam int IDX_W = ADDR_W - 3;
  localparam int CTL_W = CTL_BANK_LSB + NUM_BANKS;

  logic [IDX_W-1:0] idx;
  logic             wr_en, msk_wr;
  logic [CTL_W-1:0] ctl_rd;
  logic             unused_addr_lsb;

  assign idx             = addr_i[ADDR_W-1:3];
  assign unused_addr_lsb = ^addr_i[2:0];
  assign wr_en           = req_i & we_i;
  assign ctl_wr_o        = wr_en && (idx == IDX_W'(REG_CTL));
  assign dly_wr_o        = wr_en && (idx == IDX_W'(REG_DLY));
  assign msk_wr          = wr_en && (idx == IDX_W'(REG_MSK));
  assign dly_val_o       = wdata_i[DLY_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o  <= '0;
      bank_o   <= '0;
      mask_o   <= '0;
      reload_o <= '0;
    end else begin
      if (ctl_wr_o) begin
        flags_o <= ctl_flags_t'(wdata_i[3:0]);
        bank_o  <= wdata_i[CTL_BANK_LSB +: NUM_BANKS];
      end else if (success_i && !flags_o.pst) begin
        flags_o.en <= 1'b0;   // one-shot self clear
      end
      if (dly_wr_o) reload_o <= dly_val_o;
      if (msk_wr)   mask_o   <= wdata_i;
    end
  end

  assign ctl_rd = {bank_o, 4'b0000, flags_o};

  always_comb begin
    rdata_o = '0;
    if (idx == IDX_W'(REG_CTL))      rdata_o = DATA_W'(ctl_rd);
    else if (idx == IDX_W'(REG_DLY)) rdata_o = DATA_W'(reload_o);
    else if (idx == IDX_W'(REG_MSK)) rdata_o = mask_o;
  end
endmodule

// File: rtl/ecc_inject_seq.sv
module ecc_inject_seq
  import ecc_inject_pkg::*;
#(
  parameter int DLY_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctl_flags_t       flags_i,
  input  logic             dly_wr_i,
  input  logic [DLY_W-1:0] dly_val_i,
  input  logic [DLY_W-1:0] reload_i,
  input  logic             acc_done_i,
  output logic             inj_valid_o,
  output logic             success_o,
  output logic [DLY_W-1:0] cnt_o
);
  logic cnt_zero;

  assign cnt_zero    = (cnt_o == '0);
  assign inj_valid_o = flags_i.en & (~flags_i.ede | cnt_zero);
  assign success_o   = inj_valid_o & acc_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (dly_wr_i) begin
      cnt_o <= dly_val_i;
    end else if (success_o && flags_i.pst) begin
      cnt_o <= reload_i;
    end else if (flags_i.en && flags_i.ede && !cnt_zero) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/ecc_inject_shape.sv
module ecc_inject_shape #(
  parameter int MASK_W = 64,
  parameter int TAG_W  = 24
) (
  input  logic              data_sel_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [MASK_W-1:0] mask_o
);
  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    if (i < TAG_W) begin : g_tag
      assign mask_o[i] = mask_i[i];
    end else begin : g_data
      assign mask_o[i] = mask_i[i] & data_sel_i;
    end
  end
endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
  import ecc_inject_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 7,
  parameter int NUM_BANKS = 8,
  parameter int DLY_W     = 32,
  parameter int TAG_W     = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_req_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic                 acc_done_i,
  output logic                 inj_valid_o,
  output logic                 inj_data_sel_o,
  output logic [NUM_BANKS-1:0] inj_bank_o,
  output logic [DATA_W-1:0]    inj_mask_o
);
  ctl_flags_t       flags;
  logic [DATA_W-1:0] mask_q;
  logic [DLY_W-1:0]  reload, dly_val, cnt;
  logic              ctl_wr, dly_wr, success;

  ecc_inject_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .DLY_W(DLY_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .success_i(success), .flags_o(flags), .bank_o(inj_bank_o),
    .mask_o(mask_q), .reload_o(reload), .ctl_wr_o(ctl_wr),
    .dly_wr_o(dly_wr), .dly_val_o(dly_val)
  );

  ecc_inject_seq #(.DLY_W(DLY_W)) u_seq (
    .clk_i, .rst_ni,
    .flags_i(flags), .dly_wr_i(dly_wr), .dly_val_i(dly_val),
    .reload_i(reload), .acc_done_i(acc_done_i),
    .inj_valid_o(inj_valid_o), .success_o(success), .cnt_o(cnt)
  );

  assign inj_data_sel_o = flags.cmp;

  ecc_inject_shape #(.MASK_W(DATA_W), .TAG_W(TAG_W)) u_shape (
    .data_sel_i(flags.cmp), .mask_i(mask_q), .mask_o(inj_mask_o)
  );
endmodule

// File: rtl/ecc_inject_chk.sv
module ecc_inject_chk #(
  parameter int DATA_W = 64,
  parameter int DLY_W  = 32,
  parameter int TAG_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inj_valid,
  input logic              acc_done,
  input logic              en,
  input logic              pst,
  input logic              ede,
  input logic              ctl_wr,
  input logic              dly_wr,
  input logic [DLY_W-1:0]  cnt,
  input logic [DLY_W-1:0]  reload,
  input logic              data_sel,
  input logic [DATA_W-1:0] mask
);
  p_valid_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid |-> en);

  p_count_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && ede && (cnt != '0) && !dly_wr |=> cnt == $past(cnt) - 1'b1);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid && !acc_done && !ctl_wr && !dly_wr |=> inj_valid);

  p_oneshot_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid && acc_done && !pst && !ctl_wr |=> !inj_valid && !en);

  p_persist_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid && acc_done && pst && !ctl_wr && !dly_wr |=> en && cnt == reload);

  p_tag_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid && !data_sel |-> (mask >> TAG_W) == '0);

  p_delay_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_wr |=> cnt == reload);
endmodule

bind ecc_inject_ctrl ecc_inject_chk #(.DATA_W(DATA_W), .DLY_W(DLY_W), .TAG_W(TAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .inj_valid(inj_valid_o), .acc_done(acc_done_i),
  .en(flags.en), .pst(flags.pst), .ede(flags.ede), .ctl_wr(ctl_wr), .dly_wr(dly_wr),
  .cnt(cnt), .reload(reload), .data_sel(inj_data_sel_o), .mask(inj_mask_o)
);

// File: tb/ecc_inject_ctrl_test.sv
`timescale 1ns/1ps
module ecc_inject_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, done = 1'b0;
  logic [6:0]  addr = '0;
  logic [63:0] wdata = '0, rdata, mask;
  logic        valid, dsel;
  logic [7:0]  bank;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ecc_inject_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .acc_done_i(done), .inj_valid_o(valid), .inj_data_sel_o(dsel),
    .inj_bank_o(bank), .inj_mask_o(mask)
  );

  // {addr, wdata, expected readback}
  localparam logic [134:0] VEC [6] = '{
    {7'd8,   64'h1234_5678_9ABC_DEF0, 64'h0000_0000_9ABC_DEF0}, // R12
    {7'd16,  64'hA5A5_5A5A_0F0F_F0F0, 64'hA5A5_5A5A_0F0F_F0F0}, // R2
    {7'd0,   64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_FF00}, // R3
    {7'd19,  64'h0000_0000_0000_0055, 64'h0000_0000_0000_0055}, // R2
    {7'd24,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0},                   // R2
    {7'd120, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0}                    // R2
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [63:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [63:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [63:0] r;
    tick(2); rst_n = 1'b1; tick(1);
    // R1 reset state
    rd(7'd0, r);  chk("R1 ctl", r, 64'h0);
    rd(7'd8, r);  chk("R1 dly", r, 64'h0);
    rd(7'd16, r); chk("R1 msk", r, 64'h0);
    chk("R1 valid", {63'h0, valid}, 64'h0);

    foreach (VEC[i]) begin
      wr(VEC[i][134:128], VEC[i][127:64]);
      rd(VEC[i][134:128], r);
      chk($sformatf("R2/R3/R12 vec%0d", i), r, VEC[i][63:0]);
    end
    rd(7'd16, r); chk("R2 unmapped write ignored", r, 64'h55);
    chk("R4 no request with enable 0", {63'h0, valid}, 64'h0);

    // R4/R6/R7 immediate one-shot on data
    wr(7'd16, 64'hDEAD_BEEF_0123_4567);
    wr(7'd0, 64'h5A09);
    chk("R4 immediate arm", {63'h0, valid}, 64'h1);
    chk("R6 bank", {56'h0, bank}, 64'h5A);
    chk("R6 data sel", {63'h0, dsel}, 64'h1);
    chk("R9 data mask full", mask, 64'hDEAD_BEEF_0123_4567);
    tick(3);
    chk("R6 hold without done", {63'h0, valid}, 64'h1);
    pulse_done();
    chk("R7 drop after done", {63'h0, valid}, 64'h0);
    rd(7'd0, r); chk("R7 enable self clear", r, 64'h5A08);

    // R11 done with nothing pending
    pulse_done();
    rd(7'd0, r); chk("R11 ctl untouched", r, 64'h5A08);
    chk("R11 no request", {63'h0, valid}, 64'h0);

    // R9 tag target
    wr(7'd16, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(7'd0, 64'h0101);
    chk("R9 tag mask", mask, 64'h0000_0000_00FF_FFFF);
    chk("R6 tag sel", {63'h0, dsel}, 64'h0);
    pulse_done();

    // R5 delayed arm, D = 3
    wr(7'd8, 64'd3);
    wr(7'd0, 64'h0005);
    tick(2);
    chk("R5 low before delay", {63'h0, valid}, 64'h0);
    tick(1);
    chk("R5 armed at delay", {63'h0, valid}, 64'h1);
    pulse_done();
    chk("R7 delayed one-shot drop", {63'h0, valid}, 64'h0);

    // R8 persist, D = 2
    wr(7'd8, 64'd2);
    wr(7'd0, 64'h0007);
    tick(1);
    chk("R8 low first count", {63'h0, valid}, 64'h0);
    tick(1);
    chk("R8 first arm", {63'h0, valid}, 64'h1);
    pulse_done();
    chk("R8 reloaded low", {63'h0, valid}, 64'h0);
    tick(1);
    chk("R8 low during reload count", {63'h0, valid}, 64'h0);
    tick(1);
    chk("R8 re-armed", {63'h0, valid}, 64'h1);
    rd(7'd0, r); chk("R8 enable kept", r, 64'h7);

    // R10 delay rewrite during countdown
    wr(7'd0, 64'h0);
    wr(7'd8, 64'd10);
    wr(7'd0, 64'h0005);
    tick(3);
    wr(7'd8, 64'd2);
    chk("R10 low after rewrite", {63'h0, valid}, 64'h0);
    tick(1);
    chk("R10 low one left", {63'h0, valid}, 64'h0);
    tick(1);
    chk("R10 armed on new count", {63'h0, valid}, 64'h1);
    rd(7'd8, r); chk("R10 reload value", r, 64'd2);

    summary();
  end
endmodule